// File: doc/BRIEF.md
# Power-Down Wake-Up Clock Controller

This block is the clock and power-control register of a small microcontroller. A single 8-bit control register holds enable bits for four clock sources, a power-down request bit, a wake-up status flag and its interrupt enable, and an enable for a post-wake settling delay. The oscillators themselves, the clock multiplexer and the CPU sleep instruction are outside the block: the sleep instruction arrives as a one-cycle `sleep_cmd` pulse, and the active clock source is given by `src_is_xtal`. The block is clocked by the selected source clock.

When the CPU issues a sleep command while the power-down request bit is set, the block enters power-down and drops `clk_gate_en`. When the request bit is clear, the sleep command leaves the block untouched and the CPU simply idles. Any bit of the `wake_evt` vector exits power-down. That event sets the status flag and clears the request bit. The system clock is then released either at once or after a settling period. The settling period is 4096 cycles for the external crystal and 256 cycles for the internal oscillator. The release is marked by a one-cycle `wake_rdy` pulse.

Protected bits change only while `unlock` is high. The power-down request bit and the write-1-to-clear flag can be written at any time. All ports are plain control and status pins, so no valid/ready handshake applies.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the control register reads with bit 0 equal to `cfg_xtal_default`, bit 2 = 1 and all other bits 0, and `clk_gate_en` = 1. With `cfg_xtal_default` = 1 it reads 0x05.
- R2: Control register bit map: bit 0 external fast crystal enable, bit 1 external 32 kHz crystal enable, bit 2 internal fast oscillator enable, bit 3 internal 10 kHz oscillator enable, bit 4 settling delay enable, bit 5 wake interrupt enable, bit 6 wake status flag, bit 7 power-down request. `osc_en[3:0]` mirrors bits 3:0.
- R3: `wake_irq` is high exactly when bits 6 and 5 are both 1.
- R4: A wake event (any bit of `wake_evt` high) sets bit 6 only while in power-down. Outside power-down it has no effect on the register.
- R5: Writing 1 to bit 6 clears it and writing 0 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R6: A write with `unlock` low leaves bits 5:0 unchanged. Bits 7 and 6 are still written.
- R7: `sleep_cmd` with bit 7 = 1 enters power-down (`pd_active` = 1, `clk_gate_en` = 0) on the next edge. With bit 7 = 0 the command has no effect.
- R8: A wake event in power-down clears bit 7 and leaves power-down on the same edge.
- R9: With bit 4 = 0, `clk_gate_en` and `wake_rdy` are 1 in the cycle after the wake edge.
- R10: With bit 4 = 1 and `src_is_xtal` = 1, `clk_gate_en` stays 0 for 4096 cycles after the wake edge and then returns to 1.
- R11: With bit 4 = 1 and `src_is_xtal` = 0, the hold is 256 cycles.
- R12: `wake_rdy` is a single-cycle pulse, high in the first cycle `clk_gate_en` is 1 again after a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected source clock |
| rst_n | input | 1 | Active-low reset |
| cfg_xtal_default | input | 1 | Reset value of the external fast crystal enable |
| unlock | input | 1 | Permits writes to protected bits 5:0 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| sleep_cmd | input | 1 | CPU sleep command pulse |
| src_is_xtal | input | 1 | 1 = external crystal active, 0 = internal oscillator |
| wake_evt | input | 8 | Wake event pulses |
| ctl_rdata | output | 8 | Control register contents |
| osc_en | output | 4 | Oscillator enables |
| wake_irq | output | 1 | Wake-up interrupt |
| clk_gate_en | output | 1 | System clock release (1 = running) |
| pd_active | output | 1 | Block is in power-down |
| wake_rdy | output | 1 | One-cycle pulse when the clock is released after wake |

## Verification
A wrong register bit shows up on `ctl_rdata` and `osc_en` one cycle after the write or event that caused it. A wrong flag also shows on `wake_irq` in that same cycle. A state machine fault shows as `clk_gate_en` or `pd_active` at the wrong level on the edge after a sleep or wake. A counter loaded with the wrong length is only visible when the clock is released. The bench therefore samples the last held cycle and the first released cycle for both settling lengths.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_XHF    = 0;
  localparam int unsigned B_XLF    = 1;
  localparam int unsigned B_IHF    = 2;
  localparam int unsigned B_ILF    = 3;
  localparam int unsigned B_DLY    = 4;
  localparam int unsigned B_IE     = 5;
  localparam int unsigned B_FLAG   = 6;
  localparam int unsigned B_PDR    = 7;
  localparam int unsigned N_PROT   = 6;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_PD     = 2'd1,
    ST_SETTLE = 2'd2
  } pwc_state_t;
endpackage

// File: rtl/pwc_ctrl_reg.sv
module pwc_ctrl_reg
  import pwc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_xtal_default,
  input  logic             unlock,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             set_flag,
  input  logic             clr_pdr,
  output logic [REG_W-1:0] q
);
  logic [REG_W-1:0] rst_val;

  always_comb begin
    rst_val        = '0;
    rst_val[B_XHF] = cfg_xtal_default;
    rst_val[B_IHF] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= rst_val;
    end else begin
      if (wr_en && unlock)
        q[N_PROT-1:0] <= wr_data[N_PROT-1:0];
      // event set wins over software clear
      if (set_flag)
        q[B_FLAG] <= 1'b1;
      else if (wr_en && wr_data[B_FLAG])
        q[B_FLAG] <= 1'b0;
      if (clr_pdr)
        q[B_PDR] <= 1'b0;
      else if (wr_en)
        q[B_PDR] <= wr_data[B_PDR];
    end
  end
endmodule

// File: rtl/pwc_settle_cnt.sv
module pwc_settle_cnt #(
  parameter int unsigned XTAL_DLY = 4096,
  parameter int unsigned IRC_DLY  = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sel_xtal,
  input  logic run,
  output logic done
);
  localparam int unsigned MAX_DLY = (XTAL_DLY > IRC_DLY) ? XTAL_DLY : IRC_DLY;
  localparam int unsigned CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] XTAL_LD = CNT_W'(XTAL_DLY - 1);
  localparam logic [CNT_W-1:0] IRC_LD  = CNT_W'(IRC_DLY - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= sel_xtal ? XTAL_LD : IRC_LD;
    else if (run && !done)
      cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pwc_pd_fsm.sv
module pwc_pd_fsm
  import pwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_cmd,
  input  logic       pd_req,
  input  logic       dly_en,
  input  logic       wake_any,
  input  logic       cnt_done,
  output pwc_state_t state,
  output logic       set_flag,
  output logic       clr_pdr,
  output logic       cnt_start,
  output logic       rdy
);
  pwc_state_t nxt;
  logic       release_now;

  always_comb begin
    nxt         = state;
    set_flag    = 1'b0;
    clr_pdr     = 1'b0;
    cnt_start   = 1'b0;
    release_now = 1'b0;
    case (state)
      ST_RUN: if (sleep_cmd && pd_req) nxt = ST_PD;
      ST_PD: if (wake_any) begin
        set_flag = 1'b1;
        clr_pdr  = 1'b1;
        if (dly_en) begin
          nxt       = ST_SETTLE;
          cnt_start = 1'b1;
        end else begin
          nxt         = ST_RUN;
          release_now = 1'b1;
        end
      end
      ST_SETTLE: if (cnt_done) begin
        nxt         = ST_RUN;
        release_now = 1'b1;
      end
      default: nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      rdy   <= 1'b0;
    end else begin
      state <= nxt;
      rdy   <= release_now;
    end
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
  import pwc_pkg::*;
#(
  parameter int unsigned N_WAKE   = 8,
  parameter int unsigned XTAL_DLY = 4096,
  parameter int unsigned IRC_DLY  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_xtal_default,
  input  logic              unlock,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              sleep_cmd,
  input  logic              src_is_xtal,
  input  logic [N_WAKE-1:0] wake_evt,
  output logic [REG_W-1:0]  ctl_rdata,
  output logic [3:0]        osc_en,
  output logic              wake_irq,
  output logic              clk_gate_en,
  output logic              pd_active,
  output logic              wake_rdy
);
  logic [REG_W-1:0] ctl_q;
  pwc_state_t       state;
  logic set_flag, clr_pdr, cnt_start, cnt_done, wake_any;

  assign wake_any = |wake_evt;

  pwc_ctrl_reg u_reg (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_xtal_default (cfg_xtal_default),
    .unlock           (unlock),
    .wr_en            (wr_en),
    .wr_data          (wr_data),
    .set_flag         (set_flag),
    .clr_pdr          (clr_pdr),
    .q                (ctl_q)
  );

  pwc_pd_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_cmd (sleep_cmd),
    .pd_req    (ctl_q[B_PDR]),
    .dly_en    (ctl_q[B_DLY]),
    .wake_any  (wake_any),
    .cnt_done  (cnt_done),
    .state     (state),
    .set_flag  (set_flag),
    .clr_pdr   (clr_pdr),
    .cnt_start (cnt_start),
    .rdy       (wake_rdy)
  );

  pwc_settle_cnt #(
    .XTAL_DLY (XTAL_DLY),
    .IRC_DLY  (IRC_DLY)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cnt_start),
    .sel_xtal (src_is_xtal),
    .run      (state == ST_SETTLE),
    .done     (cnt_done)
  );

  assign ctl_rdata   = ctl_q;
  assign osc_en      = ctl_q[B_ILF:B_XHF];
  assign wake_irq    = ctl_q[B_FLAG] & ctl_q[B_IE];
  assign pd_active   = (state == ST_PD);
  assign clk_gate_en = (state == ST_RUN);
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk #(
  parameter int unsigned N_WAKE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unlock,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              sleep_cmd,
  input logic [N_WAKE-1:0] wake_evt,
  input logic [7:0]        ctl_rdata,
  input logic              wake_irq,
  input logic              clk_gate_en,
  input logic              pd_active,
  input logic              wake_rdy
);
  // R3: no interrupt without its enable
  a_r3_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[5] |-> !wake_irq);

  // R6: locked writes keep protected bits
  a_r6_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlock) |=> $stable(ctl_rdata[5:0]));

  // R4, R5: wake in power-down always leaves the flag set
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && (|wake_evt)) |=> ctl_rdata[6]);

  // R8: wake clears the request and leaves power-down
  a_r8_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && (|wake_evt)) |=> (!ctl_rdata[7] && !pd_active));

  // R9: no delay releases the clock at once
  a_r9_no_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && (|wake_evt) && !ctl_rdata[4]) |=> (clk_gate_en && wake_rdy));

  // R7: clock gated in power-down
  a_r7_gated_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> !clk_gate_en);

  // R7: sleep without request changes nothing
  a_r7_idle_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_gate_en && sleep_cmd && !ctl_rdata[7]) |=> clk_gate_en);

  // R12: ready is one cycle wide and only with a running clock
  a_r12_rdy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rdy |=> !wake_rdy);
  a_r12_rdy_with_clk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_rdy |-> clk_gate_en);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk #(.N_WAKE(N_WAKE)) u_chk (.*);

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;
  localparam int TCK = 10;
  localparam int XD  = 4096;
  localparam int ID  = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_xtal_default = 1'b1, unlock = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic sleep_cmd = 1'b0, src_is_xtal = 1'b1;
  logic [7:0] wake_evt = '0;
  logic [7:0] ctl_rdata;
  logic [3:0] osc_en;
  logic wake_irq, clk_gate_en, pd_active, wake_rdy;

  int n_chk = 0, n_fail = 0;

  always #(TCK/2) clk = ~clk;

  pwr_wake_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic unl);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; unlock = unl;
    @(negedge clk);
    wr_en = 1'b0; unlock = 1'b0;
  endtask

  task automatic sleep();
    @(negedge clk); sleep_cmd = 1'b1;
    @(negedge clk); sleep_cmd = 1'b0;
  endtask

  task automatic wake(input logic [7:0] ev);
    @(negedge clk); wake_evt = ev;
    @(negedge clk); wake_evt = '0;
  endtask

  task automatic t_reset();
    chk("R1 reset ctl", ctl_rdata, 8'h05);
    chk("R1 reset clk", clk_gate_en, 1);
    chk("R2 osc_en", osc_en, 4'h5);
    chk("R3 reset irq", wake_irq, 0);
  endtask

  task automatic t_lock();
    wr(8'h3A, 1'b0);
    chk("R6 locked write", ctl_rdata, 8'h05);
    wr(8'h35, 1'b1);
    chk("R6 unlocked write", ctl_rdata, 8'h35);
    chk("R2 osc_en map", osc_en, 4'h5);
  endtask

  task automatic t_idle_sleep();
    sleep();
    chk("R7 idle sleep pd", pd_active, 0);
    chk("R7 idle sleep clk", clk_gate_en, 1);
    wake(8'h01);
    chk("R4 wake outside pd", ctl_rdata, 8'h35);
  endtask

  task automatic t_wake_dly(input logic xt, input int d, input string tag);
    src_is_xtal = xt;
    wr(8'h80, 1'b0);
    chk({tag, " R7 req set"}, ctl_rdata, 8'hB5);
    sleep();
    chk({tag, " R7 pd entry"}, pd_active, 1);
    chk({tag, " R7 gated"}, clk_gate_en, 0);
    wake(8'h10);
    chk({tag, " R8 req cleared"}, ctl_rdata, 8'h75);
    chk({tag, " R8 pd exit"}, pd_active, 0);
    chk({tag, " R3 irq"}, wake_irq, 1);
    repeat (d - 1) @(negedge clk);
    chk({tag, " last held cycle"}, clk_gate_en, 0);
    @(negedge clk);
    chk({tag, " released"}, clk_gate_en, 1);
    chk({tag, " R12 rdy"}, wake_rdy, 1);
    @(negedge clk);
    chk({tag, " R12 rdy drop"}, wake_rdy, 0);
  endtask

  task automatic t_w1c();
    wr(8'h00, 1'b0);
    chk("R5 write 0 keeps flag", ctl_rdata, 8'h75);
    wr(8'h40, 1'b0);
    chk("R5 w1c clears", ctl_rdata, 8'h35);
    chk("R3 irq low", wake_irq, 0);
  endtask

  task automatic t_nodly();
    wr(8'h25, 1'b1);
    wr(8'h80, 1'b0);
    sleep();
    chk("R9 in pd", clk_gate_en, 0);
    wake(8'h80);
    chk("R9 clk at once", clk_gate_en, 1);
    chk("R9 rdy", wake_rdy, 1);
    chk("R9 flag", ctl_rdata, 8'h65);
    wr(8'h40, 1'b0);
  endtask

  task automatic t_set_prio();
    wr(8'h80, 1'b0);
    sleep();
    @(negedge clk);
    wake_evt = 8'h02; wr_en = 1'b1; wr_data = 8'h40;
    @(negedge clk);
    wake_evt = '0; wr_en = 1'b0;
    chk("R5 set beats clear", ctl_rdata, 8'h65);
    wr(8'h40, 1'b0);
    chk("R5 cleared after", ctl_rdata, 8'h25);
  endtask

  task automatic t_irq_mask();
    wr(8'h05, 1'b1);
    wr(8'h80, 1'b0);
    sleep();
    wake(8'h04);
    chk("R3 masked flag", ctl_rdata, 8'h45);
    chk("R3 masked irq", wake_irq, 0);
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_idle_sleep();
    t_wake_dly(1'b1, XD, "R10 xtal");
    t_w1c();
    t_wake_dly(1'b0, ID, "R11 irc");
    wr(8'h40, 1'b0);
    t_nodly();
    t_set_prio();
    t_irq_mask();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule